// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sequences an analog-to-digital converter. It decides which input channel is sampled at each step of a conversion sequence. It also decides when a sequence starts, when it is restarted and when it stops. Software writes one control word that holds four settings: a bank select for the alternate (special) channels, a repeat-forever flag, a step-across-channels flag and a 4-bit start channel. Any such write cancels the sequence in progress.

The block drives a 5-bit channel bus and a one-cycle sample strobe to the converter, and waits for the converter's done pulse before it moves on. Sequence length, wrap channel and external-trigger enable come in as plain inputs. When triggering is enabled, a control write only arms the block. After that, each rising edge of the trigger input runs exactly one sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With triggering disabled, a control write aborts any running sequence. In the next cycle the sample strobe is high, carrying the newly written start channel, and the conversion count starts again from zero.
- R2: With triggering enabled, a control write arms the block without starting it. Only a rising edge of the trigger input after that write starts a sequence. Trigger edges seen before the first arming write start nothing.
- R3: With triggering disabled, scan=1 starts sequences back to back with no idle cycle between them, and scan=0 runs one sequence and goes idle. With triggering enabled, the scan flag is ignored: each trigger runs exactly one sequence.
- R4: With the multi flag clear, every conversion of a sequence uses the start channel.
- R5: With the multi flag set, each conversion uses the previous channel plus one. A sequence has as many conversions as the length input gives, and a length of 0 means 16.
- R6: While stepping, the channel that follows the wrap channel is channel 0.
- R7: If the start channel is above the wrap channel, stepping runs up to 15 and then continues at 0. Every later wrap uses the wrap channel.
- R8: The channel bus is {special bit, 4-bit channel}, so bit 4 follows control bit 6.
- R9: After reset all control bits are 0 and the block is idle with all outputs low. Readback shows channel code in [3:0], multi in bit 4, scan in bit 5 and special in bit 6, with bit 7 always reading 0.
- R10: Busy is high from the first sample strobe until the sequence's last done pulse. Sequence-complete is a single-cycle pulse in the cycle after that last done. A trigger edge that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write data |
| ctl_rdata_o | output | 8 | Control word readback |
| wrap_ch_i | input | 4 | Last channel before stepping returns to 0 |
| seq_len_i | input | 4 | Conversions per sequence, 0 means 16 |
| trig_en_i | input | 1 | External trigger enable |
| trig_i | input | 1 | External trigger, rising edge starts a sequence |
| conv_done_i | input | 1 | Converter done pulse |
| chan_o | output | 5 | Selected channel {special, code} |
| sample_o | output | 1 | Start-of-sample strobe, one cycle |
| busy_o | output | 1 | Sequence in progress |
| seq_done_o | output | 1 | Sequence complete pulse |

## Verification
If the channel stepper holds a wrong channel or a wrong wrap state, the fault shows on chan_o with the very next sample strobe. This is at most one conversion latency after the done pulse that caused it, so the bench logs every strobed channel. A wrong conversion count or a wrong state in the state machine shows as extra or missing strobes. It can also show as a busy or seq_done edge that comes early or late, or as a sequence that restarts when it should stop. A bad arming or trigger-edge flag shows as strobes that appear with no arming write, or as a dead block after one. The bench watches for long quiet windows to catch both cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic              spec;
    logic              scan;
    logic              multi;
    logic [CODE_W-1:0] code;
  } seq_ctl_t;
endpackage

// File: rtl/adc_seq_ctl_reg.sv
module adc_seq_ctl_reg
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output seq_ctl_t          ctl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CTL_W = $bits(seq_ctl_t);

  seq_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (we_i) ctl_q <= seq_ctl_t'(wdata_i[CTL_W-1:0]);
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = DATA_W'(ctl_q);

  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_q)); // R9
endmodule

// File: rtl/adc_seq_chan_step.sv
module adc_seq_chan_step #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] start_i,
  input  logic [CODE_W-1:0] wrap_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] chan_o
);
  localparam logic [CODE_W-1:0] TOP_CH = '1;

  logic [CODE_W-1:0] chan_q, wrap_q;
  logic              above_q; // started past wrap, first wrap at TOP_CH

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      wrap_q  <= '0;
      above_q <= 1'b0;
    end else if (load_i) begin
      chan_q  <= start_i;
      wrap_q  <= wrap_i;
      above_q <= start_i > wrap_i;
    end else if (step_i) begin
      if (above_q) begin
        chan_q <= chan_q + 1'b1;
        if (chan_q == TOP_CH) above_q <= 1'b0;
      end else begin
        chan_q <= (chan_q == wrap_q) ? '0 : chan_q + 1'b1;
      end
    end
  end

  assign chan_o = chan_q;

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !above_q && chan_q == wrap_q |=> chan_q == '0); // R6
  AST_TOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && above_q && chan_q == TOP_CH |=> chan_q == '0 && !above_q); // R7
  AST_HOLD_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(chan_q)); // R4
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,      // any control write
  input  logic             abort_run_i,  // control write that starts at once
  input  logic             start_i,      // armed trigger edge
  input  logic             done_i,
  input  logic             scan_i,       // repeat, already masked by trigger enable
  input  logic [LEN_W-1:0] len_i,
  output seq_state_e       state_o,
  output logic             load_o,
  output logic             step_o,
  output logic             seq_done_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(1) << LEN_W;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, len_q, len_eff;
  logic             conv_fin, last, seq_done_q;

  assign len_eff  = (len_i == '0) ? FULL_LEN : CNT_W'(len_i);
  assign conv_fin = (state_q == ST_WAIT) && done_i;
  assign last     = conv_fin && (cnt_q + 1'b1 == len_q);
  assign load_o   = abort_run_i
                  || (!abort_i && start_i && state_q == ST_IDLE)
                  || (!abort_i && last && scan_i);
  assign step_o   = conv_fin && !last && !abort_i;

  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = abort_run_i ? ST_SAMPLE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (start_i) state_d = ST_SAMPLE;
        ST_SAMPLE: state_d = ST_WAIT;
        ST_WAIT:   if (conv_fin) state_d = (last && !scan_i) ? ST_IDLE : ST_SAMPLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      len_q      <= FULL_LEN;
      seq_done_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      seq_done_q <= last && !abort_i;
      if (load_o) begin
        cnt_q <= '0;
        len_q <= len_eff;
      end else if (conv_fin) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o    = state_q;
  assign seq_done_o = seq_done_q;

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_run_i |=> state_q == ST_SAMPLE && cnt_q == '0); // R1
  AST_ARM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && !abort_run_i |=> state_q == ST_IDLE); // R2
  AST_SAMPLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SAMPLE && !abort_i |=> state_q == ST_WAIT); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE && !abort_i && !last |=> state_q != ST_IDLE); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_q |=> !seq_done_q); // R10
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_fin |-> cnt_q < len_q); // R5
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  output logic [DATA_W-1:0] ctl_rdata_o,
  input  logic [CODE_W-1:0] wrap_ch_i,
  input  logic [LEN_W-1:0]  seq_len_i,
  input  logic              trig_en_i,
  input  logic              trig_i,
  input  logic              conv_done_i,
  output logic [CODE_W:0]   chan_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              seq_done_o
);
  seq_ctl_t          ctl_q, ctl_wr;
  seq_state_e        state;
  logic              trig_q, trig_evt, armed_q;
  logic              abort_run, trig_start, load, step;
  logic [CODE_W-1:0] cur_ch, start_ch;

  assign ctl_wr = seq_ctl_t'(ctl_wdata_i[$bits(seq_ctl_t)-1:0]);

  adc_seq_ctl_reg #(.DATA_W(DATA_W)) i_ctl_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl_q),
    .rdata_o (ctl_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (ctl_we_i) armed_q <= trig_en_i;
    end
  end

  assign trig_evt   = trig_i && !trig_q;
  assign trig_start = trig_en_i && armed_q && trig_evt;
  assign abort_run  = ctl_we_i && !trig_en_i;
  // a write loads the new code in the same edge it updates the register
  assign start_ch   = ctl_we_i ? ctl_wr.code : ctl_q.code;

  adc_seq_fsm #(.LEN_W(LEN_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (ctl_we_i),
    .abort_run_i (abort_run),
    .start_i     (trig_start),
    .done_i      (conv_done_i),
    .scan_i      (ctl_q.scan && !trig_en_i),
    .len_i       (seq_len_i),
    .state_o     (state),
    .load_o      (load),
    .step_o      (step),
    .seq_done_o  (seq_done_o)
  );

  adc_seq_chan_step #(.CODE_W(CODE_W)) i_chan_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .start_i (start_ch),
    .wrap_i  (wrap_ch_i),
    .step_i  (step && ctl_q.multi),
    .chan_o  (cur_ch)
  );

  assign chan_o   = {ctl_q.spec, cur_ch};
  assign sample_o = (state == ST_SAMPLE);
  assign busy_o   = (state != ST_IDLE);

  AST_WRITE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_run |=> sample_o && chan_o[CODE_W-1:0] == $past(ctl_wdata_i[CODE_W-1:0])); // R1
  AST_UNARMED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !armed_q && !ctl_we_i |=> !busy_o); // R2
  AST_SINGLE_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o && !ctl_q.multi |-> chan_o[CODE_W-1:0] == ctl_q.code); // R4
  AST_SPEC_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> chan_o[CODE_W] == ctl_rdata_o[6]); // R8
  AST_TRIG_ONE_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o && trig_en_i && !$past(ctl_we_i) |-> !busy_o); // R3
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int LAT = 3;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0, ctl_rdata_o;
  logic [3:0] wrap_ch_i = 4'd15, seq_len_i = 4'd1;
  logic       trig_en_i = 1'b0, trig_i = 1'b0, conv_done_i = 1'b0;
  logic [4:0] chan_o;
  logic       sample_o, busy_o, seq_done_o;

  int total = 0, bad = 0, n_samp = 0, n_done = 0, dly = 0;
  logic [4:0] chlog [64];
  bit finished = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .ctl_rdata_o(ctl_rdata_o), .wrap_ch_i(wrap_ch_i), .seq_len_i(seq_len_i),
    .trig_en_i(trig_en_i), .trig_i(trig_i), .conv_done_i(conv_done_i),
    .chan_o(chan_o), .sample_o(sample_o), .busy_o(busy_o), .seq_done_o(seq_done_o)
  );

  // converter model and monitor, away from the active edge
  always @(negedge clk) begin
    conv_done_i = 1'b0;
    if (!rst_ni) dly = 0;
    else if (sample_o) dly = LAT;
    else if (dly != 0) begin
      dly = dly - 1;
      if (dly == 0) conv_done_i = 1'b1;
    end
    if (sample_o) begin
      if (n_samp < 64) chlog[n_samp] = chan_o;
      n_samp++;
    end
    if (seq_done_o) n_done++;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(logic [7:0] d);
    tick();
    ctl_we_i = 1'b1; ctl_wdata_i = d; n_samp = 0; n_done = 0;
    tick();
    ctl_we_i = 1'b0;
  endtask

  task automatic wait_done(int target);
    for (int i = 0; i < 2000 && n_done < target; i++) tick();
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1; tick(); trig_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; tick(); tick();
    chk("R9 rdata", ctl_rdata_o, 0);
    chk("R9 busy", busy_o, 0);
    chk("R9 sample", sample_o, 0);
    chk("R9 seq_done", seq_done_o, 0);
    chk("R9 chan", chan_o, 0);
    rst_ni = 1'b1; tick();
  endtask

  task automatic t_readback_single();
    seq_len_i = 4'd4; wrap_ch_i = 4'd15;
    write_ctl(8'h89); // bit7 set, code 9, single channel
    chk("R9 readback", ctl_rdata_o, 8'h09);
    chk("R1 strobe after write", sample_o, 1);
    chk("R10 busy at first strobe", busy_o, 1);
    wait_done(1);
    chk("R10 busy low after done", busy_o, 0);
    chk("R4 count", n_samp, 4);
    for (int i = 0; i < 4; i++) chk("R4 channel", chlog[i], 5'd9);
    repeat (20) tick();
    chk("R3 single stops", n_samp, 4);
    chk("R10 one done pulse", n_done, 1);
  endtask

  task automatic t_abort();
    seq_len_i = 4'd8; wrap_ch_i = 4'd15;
    write_ctl(8'h10);
    for (int i = 0; i < 500 && n_samp < 2; i++) tick();
    write_ctl(8'h05);
    chk("R1 restart strobe", sample_o, 1);
    chk("R1 restart chan", chan_o, 5'd5);
    wait_done(1);
    chk("R1 fresh count", n_samp, 8);
    chk("R1 one done", n_done, 1);
    for (int i = 0; i < 8; i++) chk("R1 chan", chlog[i], 5'd5);
  endtask

  task automatic t_multi_wrap();
    seq_len_i = 4'd5; wrap_ch_i = 4'd5;
    write_ctl(8'h14);
    wait_done(1);
    chk("R5 count", n_samp, 5);
    chk("R5 ch0", chlog[0], 4); chk("R6 ch1", chlog[1], 5);
    chk("R6 ch2", chlog[2], 0); chk("R5 ch3", chlog[3], 1);
    chk("R5 ch4", chlog[4], 2);
  endtask

  task automatic t_above_wrap();
    seq_len_i = 4'd6; wrap_ch_i = 4'd2;
    write_ctl(8'h1E);
    wait_done(1);
    chk("R7 count", n_samp, 6);
    chk("R7 ch0", chlog[0], 14); chk("R7 ch1", chlog[1], 15);
    chk("R7 ch2", chlog[2], 0);  chk("R7 ch3", chlog[3], 1);
    chk("R7 ch4", chlog[4], 2);  chk("R7 ch5", chlog[5], 0);
  endtask

  task automatic t_len16();
    seq_len_i = 4'd0; wrap_ch_i = 4'd15;
    write_ctl(8'h10);
    wait_done(1);
    chk("R5 len0 count", n_samp, 16);
    for (int i = 0; i < 16; i++) chk("R5 len0 chan", chlog[i], i);
  endtask

  task automatic t_special();
    seq_len_i = 4'd2;
    write_ctl(8'h41);
    wait_done(1);
    chk("R8 count", n_samp, 2);
    chk("R8 chan0", chlog[0], 5'h11);
    chk("R8 chan1", chlog[1], 5'h11);
  endtask

  task automatic t_scan();
    seq_len_i = 4'd2;
    write_ctl(8'h23);
    wait_done(2);
    tick();
    chk("R3 scan keeps busy", busy_o, 1);
    chk("R3 scan repeats", n_samp >= 4, 1);
    write_ctl(8'h03);
    wait_done(1);
    repeat (20) tick();
    chk("R3 stop after scan clear", n_samp, 2);
    chk("R3 idle", busy_o, 0);
  endtask

  task automatic t_trigger();
    t_reset();
    seq_len_i = 4'd3; wrap_ch_i = 4'd15; trig_en_i = 1'b1;
    n_samp = 0;
    pulse_trig();
    repeat (20) tick();
    chk("R2 unarmed trigger", n_samp, 0);
    write_ctl(8'h32); // scan + multi, code 2
    chk("R2 arm no strobe", sample_o, 0);
    chk("R2 arm no busy", busy_o, 0);
    repeat (10) tick();
    chk("R2 armed waits", n_samp, 0);
    pulse_trig();
    wait_done(1);
    chk("R2 trigger runs", n_samp, 3);
    chk("R2 ch0", chlog[0], 2); chk("R2 ch1", chlog[1], 3);
    chk("R2 ch2", chlog[2], 4);
    repeat (30) tick();
    chk("R3 scan ignored", n_samp, 3);
    n_samp = 0; n_done = 0;
    pulse_trig();
    for (int i = 0; i < 500 && n_samp < 2; i++) tick();
    pulse_trig();
    wait_done(1);
    repeat (40) tick();
    chk("R10 busy trigger ignored", n_samp, 3);
    chk("R10 done once", n_done, 1);
    trig_en_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_readback_single();
    t_abort();
    t_multi_wrap();
    t_above_wrap();
    t_len16();
    t_special();
    t_scan();
    t_trigger();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule